// File: doc/BRIEF.md
# Software Store Command Sequence Detector

This block sits beside a host-facing memory port and watches each completed access. When the host performs six reads in a row at a fixed series of magic addresses, with no other access in between, the detector raises a one-cycle store request. This lets a controller copy the volatile array into nonvolatile storage using ordinary reads only, so the port keeps plain SRAM timing and behaviour.

The detector only watches accesses. It never stalls the bus, and the reads it observes still return their normal data. While the store controller reports that it is busy, the detector ignores all accesses and stays in its idle step. A read or write that breaks the series sends progress back to the start. The exception is an aborting read at the first magic address, which starts a new series at step one.

Top module: `store_seq_detector`

## Requirements
- R1: After a synchronous reset, `store_req` is low and the detector is idle, so a lone read at 0x0FC0 does not request a store.
- R2: Completed reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, in that order, drive `store_req` high for exactly one cycle. That cycle follows the clock edge that samples the sixth strobe.
- R3: A completed write (`acc_is_read` low) at any point in the series returns progress to idle.
- R4: A completed read at an address other than the next expected one returns progress to idle.
- R5: An aborting read at 0x0E38 is counted as step one of a new series.
- R6: While `busy` is high, completed accesses are ignored, progress returns to idle, and `store_req` stays low.
- R7: Address and direction changes without `acc_done` have no effect on progress or on `store_req`.
- R8: After a request, progress is idle, and a following complete series produces another request.
- R9: The magic addresses presented out of order never produce a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_done | input | 1 | One-cycle strobe marking a completed host access |
| acc_is_read | input | 1 | 1 for a read, 0 for a write; valid with `acc_done` |
| acc_addr | input | 15 | Word address of the completed access |
| busy | input | 1 | Store controller is executing a store |
| store_req | output | 1 | One-cycle store request pulse |

## Verification
A wrong step value inside the detector stays hidden until the sixth read of a series. At that point it shows up as a missing or extra `store_req` pulse one cycle after that read. For this reason, each abort case is followed by the rest of a series, so that any stale progress shows up as a wrong pulse. A lost clear after `busy` would show up as a request from the busy-time accesses combined with the reads that follow them.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int unsigned ADDR_W   = 15;
    localparam int unsigned SEQ_LEN  = 6;
    localparam int unsigned STEP_W   = $clog2(SEQ_LEN);
    localparam int unsigned STEP_SPAN = 1 << STEP_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam step_t LAST_STEP = step_t'(SEQ_LEN - 1);

    typedef struct packed {
        logic  valid;
        logic  rd;
        addr_t addr;
    } access_t;

    // Magic address expected at each step of the series.
    function automatic addr_t magic_addr(input int unsigned idx);
        case (idx)
            0:       return addr_t'(15'h0E38);
            1:       return addr_t'(15'h31C7);
            2:       return addr_t'(15'h03E0);
            3:       return addr_t'(15'h3C1F);
            4:       return addr_t'(15'h303F);
            default: return addr_t'(15'h0FC0);
        endcase
    endfunction

endpackage

// File: rtl/seqdet_match.sv
module seqdet_match
    import seqdet_pkg::*;
(
    input  access_t acc,
    input  step_t   step,
    output logic    hit_next,
    output logic    hit_first
);
    logic [STEP_SPAN-1:0] hit_vec;

    for (genvar i = 0; i < STEP_SPAN; i++) begin : g_cmp
        if (i < SEQ_LEN) begin : g_real
            assign hit_vec[i] = acc.rd && (acc.addr == magic_addr(i));
        end else begin : g_pad
            assign hit_vec[i] = 1'b0;
        end
    end

    assign hit_next  = hit_vec[step];
    assign hit_first = hit_vec[0];
endmodule

// File: rtl/seqdet_step_ctr.sv
module seqdet_step_ctr
    import seqdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  valid,
    input  logic  hit_next,
    input  logic  hit_first,
    output step_t step,
    output logic  fire
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (valid) begin
                if (hit_next) begin
                    if (step == LAST_STEP) begin
                        step <= '0;
                        fire <= 1'b1;
                    end else begin
                        step <= step + step_t'(1);
                    end
                end else if (hit_first) begin
                    step <= step_t'(1);
                end else begin
                    step <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/store_seq_detector.sv
module store_seq_detector
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_done,
    input  logic              acc_is_read,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              busy,
    output logic              store_req
);
    access_t acc;
    step_t   step;
    logic    hit_next;
    logic    hit_first;

    assign acc.valid = acc_done && !busy;
    assign acc.rd    = acc_is_read;
    assign acc.addr  = acc_addr;

    seqdet_match u_match (
        .acc       (acc),
        .step      (step),
        .hit_next  (hit_next),
        .hit_first (hit_first)
    );

    seqdet_step_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .clear     (busy),
        .valid     (acc.valid),
        .hit_next  (hit_next),
        .hit_first (hit_first),
        .step      (step),
        .fire      (store_req)
    );
endmodule

// File: rtl/store_seq_detector_chk.sv
module store_seq_detector_chk
    import seqdet_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_done,
    input logic              acc_is_read,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              busy,
    input logic              store_req,
    input step_t             step
);
    // R2: the request lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);

    // R2: a request follows a completed read at the final address
    a_r2_final_read: assert property (@(posedge clk) disable iff (rst)
        store_req |-> $past(acc_done && acc_is_read && !busy &&
                            acc_addr == magic_addr(SEQ_LEN - 1)));

    // R6: busy blocks the request and clears progress
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (!store_req && step == '0));

    // R7: no strobe, no request
    a_r7_need_strobe: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_done) |-> !store_req);

    // R7: no strobe, no progress change
    a_r7_step_hold: assert property (@(posedge clk) disable iff (rst)
        (!acc_done && !busy) |=> $stable(step));

    // R3: a write returns progress to idle
    a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !acc_is_read) |=> step == '0);

    // R8: progress stays within the series
    a_r8_step_range: assert property (@(posedge clk) disable iff (rst)
        step <= LAST_STEP);
endmodule

bind store_seq_detector store_seq_detector_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_done    (acc_done),
    .acc_is_read (acc_is_read),
    .acc_addr    (acc_addr),
    .busy        (busy),
    .store_req   (store_req),
    .step        (step)
);

// File: tb/store_seq_detector_test.sv
module store_seq_detector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_done = 1'b0;
    logic        acc_is_read = 1'b1;
    logic [14:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic        store_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    store_seq_detector uut (
        .clk(clk), .rst(rst), .acc_done(acc_done), .acc_is_read(acc_is_read),
        .acc_addr(acc_addr), .busy(busy), .store_req(store_req)
    );

    // vector: [19] busy, [18] read, [17] expected store_req, [16:15] req tag, [14:0] addr
    localparam int NV = 39;
    localparam logic [19:0] VEC [NV] = '{
        // R2 full series
        {1'b0,1'b1,1'b0,2'd0,15'h0E38}, {1'b0,1'b1,1'b0,2'd0,15'h31C7},
        {1'b0,1'b1,1'b0,2'd0,15'h03E0}, {1'b0,1'b1,1'b0,2'd0,15'h3C1F},
        {1'b0,1'b1,1'b0,2'd0,15'h303F}, {1'b0,1'b1,1'b1,2'd0,15'h0FC0},
        // R3 write breaks
        {1'b0,1'b1,1'b0,2'd1,15'h0E38}, {1'b0,1'b1,1'b0,2'd1,15'h31C7},
        {1'b0,1'b0,1'b0,2'd1,15'h03E0}, {1'b0,1'b1,1'b0,2'd1,15'h03E0},
        {1'b0,1'b1,1'b0,2'd1,15'h3C1F}, {1'b0,1'b1,1'b0,2'd1,15'h303F},
        {1'b0,1'b1,1'b0,2'd1,15'h0FC0},
        // R4 stray read breaks
        {1'b0,1'b1,1'b0,2'd2,15'h0E38}, {1'b0,1'b1,1'b0,2'd2,15'h31C7},
        {1'b0,1'b1,1'b0,2'd2,15'h03E0}, {1'b0,1'b1,1'b0,2'd2,15'h1234},
        {1'b0,1'b1,1'b0,2'd2,15'h3C1F}, {1'b0,1'b1,1'b0,2'd2,15'h303F},
        {1'b0,1'b1,1'b0,2'd2,15'h0FC0},
        // R5 aborting read at first address restarts at step one
        {1'b0,1'b1,1'b0,2'd3,15'h0E38}, {1'b0,1'b1,1'b0,2'd3,15'h31C7},
        {1'b0,1'b1,1'b0,2'd3,15'h0E38}, {1'b0,1'b1,1'b0,2'd3,15'h31C7},
        {1'b0,1'b1,1'b0,2'd3,15'h03E0}, {1'b0,1'b1,1'b0,2'd3,15'h3C1F},
        {1'b0,1'b1,1'b0,2'd3,15'h303F}, {1'b0,1'b1,1'b1,2'd3,15'h0FC0},
        // R6 busy access ignored and clears
        {1'b0,1'b1,1'b0,2'd0,15'h0E38}, {1'b0,1'b1,1'b0,2'd0,15'h31C7},
        {1'b0,1'b1,1'b0,2'd0,15'h03E0}, {1'b0,1'b1,1'b0,2'd0,15'h3C1F},
        {1'b0,1'b1,1'b0,2'd0,15'h303F}, {1'b1,1'b1,1'b0,2'd0,15'h0FC0},
        {1'b0,1'b1,1'b0,2'd0,15'h0FC0},
        // R9 out of order
        {1'b0,1'b1,1'b0,2'd0,15'h31C7}, {1'b0,1'b1,1'b0,2'd0,15'h0E38},
        {1'b0,1'b1,1'b0,2'd0,15'h3C1F}, {1'b0,1'b1,1'b0,2'd0,15'h0FC0}
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (store_req !== exp) begin
            errors++;
            $display("FAIL %s store_req actual=%b expected=%b", req, store_req, exp);
        end
    endtask

    // one completed access; result sampled on the following falling edge
    task automatic access(input logic b, input logic rd, input logic [14:0] a,
                          input logic exp, input string req);
        busy = b; acc_is_read = rd; acc_addr = a; acc_done = 1'b1;
        @(posedge clk); @(negedge clk);
        acc_done = 1'b0; busy = 1'b0;
        check(exp, req);
    endtask

    task automatic series(input logic exp, input string req);
        access(0, 1, 15'h0E38, 0, req);
        access(0, 1, 15'h31C7, 0, req);
        access(0, 1, 15'h03E0, 0, req);
        access(0, 1, 15'h3C1F, 0, req);
        access(0, 1, 15'h303F, 0, req);
        access(0, 1, 15'h0FC0, exp, req);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        string tags [4] = '{"R2/R9/R6", "R3", "R4", "R5"};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(1'b0, "R1");                                  // R1 reset state
        access(0, 1, 15'h0FC0, 0, "R1");                    // R1 idle after reset

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][19], VEC[i][18], VEC[i][14:0], VEC[i][17], tags[VEC[i][16:15]]);
        end

        // R2 pulse lasts exactly one cycle
        series(1, "R2");
        @(negedge clk);
        check(0, "R2");

        // R8 back-to-back series
        series(1, "R8");
        series(1, "R8");
        access(0, 1, 15'h0FC0, 0, "R8");

        // R7 input wiggles without strobe
        access(0, 1, 15'h0E38, 0, "R7");
        access(0, 1, 15'h31C7, 0, "R7");
        access(0, 1, 15'h03E0, 0, "R7");
        access(0, 1, 15'h3C1F, 0, "R7");
        access(0, 1, 15'h303F, 0, "R7");
        acc_is_read = 0; acc_addr = 15'h1111;
        @(negedge clk); check(0, "R7");
        acc_is_read = 1; acc_addr = 15'h0FC0;
        repeat (3) @(negedge clk); check(0, "R7");
        access(0, 1, 15'h0FC0, 1, "R7");

        // R6 busy without access clears progress
        access(0, 1, 15'h0E38, 0, "R6");
        access(0, 1, 15'h31C7, 0, "R6");
        busy = 1'b1; @(negedge clk); busy = 1'b0;
        check(0, "R6");
        access(0, 1, 15'h03E0, 0, "R6");
        access(0, 1, 15'h3C1F, 0, "R6");
        access(0, 1, 15'h303F, 0, "R6");
        access(0, 1, 15'h0FC0, 0, "R6");

        // R1 reset mid-series
        access(0, 1, 15'h0E38, 0, "R1");
        access(0, 1, 15'h31C7, 0, "R1");
        access(0, 1, 15'h03E0, 0, "R1");
        access(0, 1, 15'h3C1F, 0, "R1");
        access(0, 1, 15'h303F, 0, "R1");
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check(0, "R1");
        access(0, 1, 15'h0FC0, 0, "R1");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule